// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This block decides control flow for a five-stage in-order pipeline while the branch or jump is still in decode. It receives the register numbers read by the decoding instruction, its branch and jump flags, the raw register-file values, and the destination, write-enable and load flags of the instructions in execute and memory. It returns one operand-source select per compare input, a stall request, a fetch-flush strobe, a next-PC select and the redirect address.

The register-file values are compared for equality only after each one passes through a forwarding mux. That mux can replace the value with the result held in the EX/MEM register. An instruction one slot ahead of the branch is still computing in execute, so its result cannot be used yet and the unit requests a stall. A load in the memory stage has no data ready either, so it also causes a stall. While the stall is active the surrounding pipeline holds PC and IF/ID and injects a bubble into ID/EX. A taken branch or a jump redirects the PC and flushes the single instruction behind it in fetch. Both target addresses are computed every cycle, whether or not they are used.

Top module: `dbr_unit`

## Requirements
- R1: When the memory-stage instruction writes a register (write enable 1, load flag 0, destination non-zero) that equals rs or rt, the matching select output is 1 (take EX/MEM value) and that value feeds the comparison; each operand is handled on its own.
- R2: A select is 0 (register-file value) when the memory-stage write enable is 0 or its destination differs; values written further back arrive through the register file without any forwarding.
- R3: A branch (beq or bne flag set) raises `stall` when the execute-stage instruction writes a non-zero register equal to rs or rt.
- R4: A branch raises `stall` when the memory-stage instruction is a load whose non-zero destination equals rs or rt, and that load is never selected for forwarding.
- R5: While `stall` is 1, `npc_sel` is 0 (sequential), `flush_if` is 0 and the branch does not redirect.
- R6: A beq whose compared operands are equal, when not stalled, gives `npc_sel` = 1, `flush_if` = 1 and `npc_target` = pc_plus4 + (sign-extended 16-bit offset × 4).
- R7: A bne is taken (`npc_sel` = 1, `flush_if` = 1) when its operands differ and is not taken when they are equal.
- R8: A branch that is not taken, or no control instruction, gives `npc_sel` = 0 and `flush_if` = 0.
- R9: A jump gives `npc_sel` = 2, `flush_if` = 1, never stalls, and `npc_target` = {pc_plus4[31:28], 26-bit field, 2'b00}.
- R10: Register 0 is never a forwarding source and never a stall source.
- R11: With neither branch flag set, no register match raises `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the built-in property checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| id_pc_plus4 | input | 32 | Address after the decoding instruction |
| id_offset | input | 16 | Branch displacement field, in words |
| id_jfield | input | 26 | Jump index field |
| id_rs | input | 5 | First source register of decode |
| id_rt | input | 5 | Second source register of decode |
| id_beq | input | 1 | Decode holds branch-if-equal |
| id_bne | input | 1 | Decode holds branch-if-not-equal |
| id_jump | input | 1 | Decode holds an unconditional jump |
| rf_rs_val | input | 32 | Register-file value of rs |
| rf_rt_val | input | 32 | Register-file value of rt |
| ex_dst | input | 5 | Destination of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| mem_dst | input | 5 | Destination in EX/MEM |
| mem_wr | input | 1 | EX/MEM instruction writes a register |
| mem_load | input | 1 | EX/MEM instruction is a load |
| mem_val | input | 32 | ALU result held in EX/MEM |
| fwd_sel_a | output | 1 | Source of compare operand A (1 = EX/MEM) |
| fwd_sel_b | output | 1 | Source of compare operand B (1 = EX/MEM) |
| stall | output | 1 | Hold PC and IF/ID, bubble into ID/EX |
| flush_if | output | 1 | Zero the fetched instruction in IF/ID |
| npc_sel | output | 2 | 0 sequential, 1 branch target, 2 jump target |
| npc_target | output | 32 | Redirect address |

## Verification
The bench builds the unit with its default 32-bit data path and 5-bit register numbers. These values keep the jump target's top-nibble splice at bits 31..28 and make the negative offsets wrap realistically. Table vectors set execute and memory hazards on each operand separately and together, so stall priority over forwarding and over the taken decision can be seen at the ports. Directed cases then compute both target formats in the bench for forward, backward and high-nibble addresses.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ    = 2'd0,
    NPC_BRANCH = 2'd1,
    NPC_JUMP   = 2'd2
  } npc_e;

  typedef enum logic {
    SRC_RF    = 1'b0,
    SRC_EXMEM = 1'b1
  } opnd_src_e;
endpackage

// File: rtl/dbr_fwd.sv
module dbr_fwd
  import dbr_pkg::*;
#(
  parameter int REGW = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REGW-1:0]       rs,
  input  logic [REGW-1:0]       rt,
  input  logic [REGW-1:0]       mem_dst,
  input  logic                  mem_wr,
  input  logic                  mem_load,
  output opnd_src_e             src_a,
  output opnd_src_e             src_b
);
  localparam int NOPND = 2;

  logic [REGW-1:0] opnd_reg [NOPND];
  opnd_src_e       opnd_src [NOPND];
  logic            mem_alu_producer;

  assign opnd_reg[0] = rs;
  assign opnd_reg[1] = rt;
  assign mem_alu_producer = mem_wr && !mem_load && (mem_dst != '0);

  for (genvar i = 0; i < NOPND; i++) begin : g_opnd
    assign opnd_src[i] = (mem_alu_producer && (mem_dst == opnd_reg[i])) ? SRC_EXMEM : SRC_RF;
  end

  assign src_a = opnd_src[0];
  assign src_b = opnd_src[1];

  AST_NO_FWD_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rs == '0) |-> (src_a == SRC_RF)); // R10
  AST_NO_FWD_OF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_load |-> (src_a == SRC_RF && src_b == SRC_RF)); // R4
  AST_NO_FWD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr |-> (src_a == SRC_RF && src_b == SRC_RF)); // R2
endmodule

// File: rtl/dbr_hazard.sv
module dbr_hazard #(
  parameter int REGW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_branch,
  input  logic [REGW-1:0] rs,
  input  logic [REGW-1:0] rt,
  input  logic [REGW-1:0] ex_dst,
  input  logic            ex_wr,
  input  logic [REGW-1:0] mem_dst,
  input  logic            mem_load,
  output logic            stall
);
  logic ex_hit;
  logic load_hit;

  assign ex_hit   = ex_wr && (ex_dst != '0) && ((ex_dst == rs) || (ex_dst == rt));
  assign load_hit = mem_load && (mem_dst != '0) && ((mem_dst == rs) || (mem_dst == rt));
  assign stall    = is_branch && (ex_hit || load_hit);

  AST_STALL_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    !is_branch |-> !stall); // R11
  AST_ZERO_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (rs == '0 && rt == '0) |-> !stall); // R10
endmodule

// File: rtl/dbr_redirect.sv
module dbr_redirect
  import dbr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic is_beq,
  input  logic is_bne,
  input  logic is_jump,
  input  logic stall,
  input  logic opnd_equal,
  output npc_e npc_sel,
  output logic flush,
  output logic taken
);
  logic cond_met;

  assign cond_met = (is_beq && opnd_equal) || (is_bne && !opnd_equal);
  assign taken    = !stall && cond_met;

  always_comb begin
    npc_sel = NPC_SEQ;
    if (stall)        npc_sel = NPC_SEQ;
    else if (is_jump) npc_sel = NPC_JUMP;
    else if (taken)   npc_sel = NPC_BRANCH;
  end

  assign flush = (npc_sel != NPC_SEQ);

  AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (npc_sel == NPC_SEQ && !flush && !taken)); // R5
  AST_JUMP_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jump && !stall) |-> (flush && npc_sel == NPC_JUMP)); // R9
  AST_NO_CTRL_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_beq && !is_bne && !is_jump) |-> !flush); // R8
endmodule

// File: rtl/dbr_unit.sv
module dbr_unit
  import dbr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int REGW = 5,
  parameter int OFFW = 16,
  parameter int JIDXW = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XLEN-1:0]  id_pc_plus4,
  input  logic [OFFW-1:0]  id_offset,
  input  logic [JIDXW-1:0] id_jfield,
  input  logic [REGW-1:0]  id_rs,
  input  logic [REGW-1:0]  id_rt,
  input  logic             id_beq,
  input  logic             id_bne,
  input  logic             id_jump,
  input  logic [XLEN-1:0]  rf_rs_val,
  input  logic [XLEN-1:0]  rf_rt_val,
  input  logic [REGW-1:0]  ex_dst,
  input  logic             ex_wr,
  input  logic [REGW-1:0]  mem_dst,
  input  logic             mem_wr,
  input  logic             mem_load,
  input  logic [XLEN-1:0]  mem_val,
  output logic             fwd_sel_a,
  output logic             fwd_sel_b,
  output logic             stall,
  output logic             flush_if,
  output logic [1:0]       npc_sel,
  output logic [XLEN-1:0]  npc_target
);
  localparam int SEXT   = XLEN - OFFW - 2;
  localparam int KEEPHI = XLEN - JIDXW - 2;

  function automatic logic [XLEN-1:0] calc_branch_target(
    input logic [XLEN-1:0] pc4, input logic [OFFW-1:0] off);
    return pc4 + {{SEXT{off[OFFW-1]}}, off, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] calc_jump_target(
    input logic [XLEN-1:0] pc4, input logic [JIDXW-1:0] idx);
    return {pc4[XLEN-1 -: KEEPHI], idx, 2'b00};
  endfunction

  opnd_src_e       src_a, src_b;
  npc_e            sel_int;
  logic            is_branch;
  logic            hz_stall;
  logic            opnd_equal;
  logic            br_taken;
  logic [XLEN-1:0] cmp_a, cmp_b;
  logic [XLEN-1:0] tgt_branch, tgt_jump;

  assign is_branch = id_beq || id_bne;

  dbr_fwd #(.REGW(REGW)) i_fwd (
    .clk(clk), .rst_n(rst_n), .rs(id_rs), .rt(id_rt),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_load(mem_load),
    .src_a(src_a), .src_b(src_b)
  );

  dbr_hazard #(.REGW(REGW)) i_hazard (
    .clk(clk), .rst_n(rst_n), .is_branch(is_branch), .rs(id_rs), .rt(id_rt),
    .ex_dst(ex_dst), .ex_wr(ex_wr), .mem_dst(mem_dst), .mem_load(mem_load),
    .stall(hz_stall)
  );

  assign cmp_a      = (src_a == SRC_EXMEM) ? mem_val : rf_rs_val;
  assign cmp_b      = (src_b == SRC_EXMEM) ? mem_val : rf_rt_val;
  assign opnd_equal = (cmp_a == cmp_b);
  assign tgt_branch = calc_branch_target(id_pc_plus4, id_offset);
  assign tgt_jump   = calc_jump_target(id_pc_plus4, id_jfield);

  dbr_redirect i_redirect (
    .clk(clk), .rst_n(rst_n), .is_beq(id_beq), .is_bne(id_bne), .is_jump(id_jump),
    .stall(hz_stall), .opnd_equal(opnd_equal),
    .npc_sel(sel_int), .flush(flush_if), .taken(br_taken)
  );

  assign fwd_sel_a  = (src_a == SRC_EXMEM);
  assign fwd_sel_b  = (src_b == SRC_EXMEM);
  assign stall      = hz_stall;
  assign npc_sel    = sel_int;
  assign npc_target = (sel_int == NPC_JUMP) ? tgt_jump : tgt_branch;

  AST_JUMP_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (npc_sel == 2'd2) |-> (npc_target[XLEN-1 -: KEEPHI] == id_pc_plus4[XLEN-1 -: KEEPHI])); // R9
  AST_BEQ_TAKEN_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && id_beq && !id_bne) |-> (rf_rs_val == rf_rt_val || fwd_sel_a || fwd_sel_b)); // R6
  AST_FWD_VALUE_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_sel_a && fwd_sel_b) |-> opnd_equal); // R1
endmodule

// File: tb/test_dbr_unit.sv
module test_dbr_unit;
  typedef struct packed {
    logic        beq, bne, jmp;
    logic [4:0]  rs, rt, exd;
    logic        exw;
    logic [4:0]  memd;
    logic        memw, memr;
    logic [31:0] rsd, rtd, memv;
    logic        fa, fb, st, fl;
    logic [1:0]  sel;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    // R8 beq, differing values, no producers
    '{1'b1,1'b0,1'b0, 5'd1,5'd2, 5'd0,1'b0, 5'd0,1'b0,1'b0, 32'd5,32'd6,32'd0, 1'b0,1'b0,1'b0,1'b0, 2'd0},
    // R6 beq equal -> taken
    '{1'b1,1'b0,1'b0, 5'd1,5'd2, 5'd0,1'b0, 5'd0,1'b0,1'b0, 32'd7,32'd7,32'd0, 1'b0,1'b0,1'b0,1'b1, 2'd1},
    // R7 bne differing -> taken
    '{1'b0,1'b1,1'b0, 5'd1,5'd2, 5'd0,1'b0, 5'd0,1'b0,1'b0, 32'd3,32'd4,32'd0, 1'b0,1'b0,1'b0,1'b1, 2'd1},
    // R7 bne equal -> not taken
    '{1'b0,1'b1,1'b0, 5'd1,5'd2, 5'd0,1'b0, 5'd0,1'b0,1'b0, 32'd4,32'd4,32'd0, 1'b0,1'b0,1'b0,1'b0, 2'd0},
    // R1 forward onto operand A makes beq equal
    '{1'b1,1'b0,1'b0, 5'd3,5'd4, 5'd0,1'b0, 5'd3,1'b1,1'b0, 32'd9,32'd5,32'd5, 1'b1,1'b0,1'b0,1'b1, 2'd1},
    // R1 forward onto operand B
    '{1'b1,1'b0,1'b0, 5'd3,5'd4, 5'd0,1'b0, 5'd4,1'b1,1'b0, 32'd5,32'd9,32'd5, 1'b0,1'b1,1'b0,1'b1, 2'd1},
    // R2 write disabled -> register file used, not equal
    '{1'b1,1'b0,1'b0, 5'd3,5'd4, 5'd0,1'b0, 5'd4,1'b0,1'b0, 32'd5,32'd9,32'd5, 1'b0,1'b0,1'b0,1'b0, 2'd0},
    // R3 execute writes rt -> stall, R5 no redirect
    '{1'b0,1'b1,1'b0, 5'd5,5'd6, 5'd6,1'b1, 5'd0,1'b0,1'b0, 32'd1,32'd2,32'd0, 1'b0,1'b0,1'b1,1'b0, 2'd0},
    // R4 load in memory writes rs -> stall, no forward, R5 equal values not taken
    '{1'b1,1'b0,1'b0, 5'd5,5'd6, 5'd0,1'b0, 5'd5,1'b1,1'b1, 32'd8,32'd8,32'd1, 1'b0,1'b0,1'b1,1'b0, 2'd0},
    // R10 register 0 everywhere: no stall, no forward, beq equal taken
    '{1'b1,1'b0,1'b0, 5'd0,5'd0, 5'd0,1'b1, 5'd0,1'b1,1'b0, 32'd0,32'd0,32'd7, 1'b0,1'b0,1'b0,1'b1, 2'd1},
    // R11 no branch flag: matches give no stall, select still reported
    '{1'b0,1'b0,1'b0, 5'd1,5'd2, 5'd1,1'b1, 5'd2,1'b1,1'b0, 32'd1,32'd2,32'd3, 1'b0,1'b1,1'b0,1'b0, 2'd0},
    // R9 jump never stalls
    '{1'b0,1'b0,1'b1, 5'd1,5'd2, 5'd1,1'b1, 5'd0,1'b0,1'b0, 32'd1,32'd2,32'd0, 1'b0,1'b0,1'b0,1'b1, 2'd2},
    // R5 execute and memory both hit rs: stall wins over forwarded equality
    '{1'b1,1'b0,1'b0, 5'd7,5'd8, 5'd7,1'b1, 5'd7,1'b1,1'b0, 32'd0,32'd4,32'd4, 1'b1,1'b0,1'b1,1'b0, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] id_pc_plus4 = '0;
  logic [15:0] id_offset = '0;
  logic [25:0] id_jfield = '0;
  logic [4:0]  id_rs = '0, id_rt = '0, ex_dst = '0, mem_dst = '0;
  logic        id_beq = 1'b0, id_bne = 1'b0, id_jump = 1'b0;
  logic        ex_wr = 1'b0, mem_wr = 1'b0, mem_load = 1'b0;
  logic [31:0] rf_rs_val = '0, rf_rt_val = '0, mem_val = '0;
  logic        fwd_sel_a, fwd_sel_b, stall, flush_if;
  logic [1:0]  npc_sel;
  logic [31:0] npc_target;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dbr_unit i_dbr_unit (
    .clk(clk), .rst_n(rst_n), .id_pc_plus4(id_pc_plus4), .id_offset(id_offset),
    .id_jfield(id_jfield), .id_rs(id_rs), .id_rt(id_rt), .id_beq(id_beq),
    .id_bne(id_bne), .id_jump(id_jump), .rf_rs_val(rf_rs_val), .rf_rt_val(rf_rt_val),
    .ex_dst(ex_dst), .ex_wr(ex_wr), .mem_dst(mem_dst), .mem_wr(mem_wr),
    .mem_load(mem_load), .mem_val(mem_val), .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
    .stall(stall), .flush_if(flush_if), .npc_sel(npc_sel), .npc_target(npc_target)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    id_beq = v.beq; id_bne = v.bne; id_jump = v.jmp;
    id_rs = v.rs; id_rt = v.rt; ex_dst = v.exd; ex_wr = v.exw;
    mem_dst = v.memd; mem_wr = v.memw; mem_load = v.memr;
    rf_rs_val = v.rsd; rf_rt_val = v.rtd; mem_val = v.memv;
    #1;
  endtask

  function automatic logic [31:0] exp_branch(input logic [31:0] pc4, input logic [15:0] off);
    logic signed [31:0] d;
    d = 32'(signed'(off)) * 4;
    return pc4 + d;
  endfunction

  function automatic logic [31:0] exp_jump(input logic [31:0] pc4, input logic [25:0] idx);
    return (pc4 & 32'hF000_0000) | (32'(idx) << 2);
  endfunction

  initial begin
    #200000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R8 idle state during reset: sequential, nothing asserted
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 reset idle", {fwd_sel_a, fwd_sel_b, stall, flush_if, npc_sel}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i]);
      check($sformatf("R1-set vector %0d", i),
            {fwd_sel_a, fwd_sel_b, stall, flush_if, npc_sel},
            {VECS[i].fa, VECS[i].fb, VECS[i].st, VECS[i].fl, VECS[i].sel});
    end

    // R6 backward branch target
    id_pc_plus4 = 32'h0040_0010; id_offset = 16'hFFFC;
    drive(VECS[1]);
    check("R6 backward target", npc_target, exp_branch(32'h0040_0010, 16'hFFFC));
    // R6 forward branch target
    id_offset = 16'h0003;
    drive(VECS[1]);
    check("R6 forward target", npc_target, exp_branch(32'h0040_0010, 16'h0003));
    // R9 jump target keeps the high nibble
    id_pc_plus4 = 32'hA000_0004; id_jfield = 26'h012_3456;
    drive(VECS[11]);
    check("R9 jump target", npc_target, exp_jump(32'hA000_0004, 26'h012_3456));
    check("R9 jump select", {stall, flush_if, npc_sel}, {1'b0, 1'b1, 2'd2});
    // R4 load feeding rt also stalls bne
    drive('{1'b0,1'b1,1'b0, 5'd9,5'd10, 5'd0,1'b0, 5'd10,1'b1,1'b1, 32'd1,32'd2,32'd0,
            1'b0,1'b0,1'b1,1'b0, 2'd0});
    check("R4 load on rt", {fwd_sel_b, stall, flush_if, npc_sel}, {1'b0, 1'b1, 1'b0, 2'd0});
    // R2 destination differs from both sources
    drive('{1'b1,1'b0,1'b0, 5'd9,5'd10, 5'd0,1'b0, 5'd11,1'b1,1'b0, 32'd2,32'd2,32'd5,
            1'b0,1'b0,1'b0,1'b1, 2'd1});
    check("R2 other dest", {fwd_sel_a, fwd_sel_b, flush_if, npc_sel}, {1'b0, 1'b0, 1'b1, 2'd1});
    // R3 execute writes rs with write enable low: no stall
    drive('{1'b1,1'b0,1'b0, 5'd9,5'd10, 5'd9,1'b0, 5'd0,1'b0,1'b0, 32'd2,32'd3,32'd0,
            1'b0,1'b0,1'b0,1'b0, 2'd0});
    check("R3 ex write off", {stall, npc_sel}, {1'b0, 2'd0});

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule